// File: doc/BRIEF.md
# Deglitched Power-Good Monitor

This block decides the level of a regulator's power-good pin. Two comparator flags come in. The high flag says the output is at or above 90% of its target. The low flag says the output has sagged 15% below target. Two qualifiers also come in: soft-start has finished, and the converter is enabled and free of latched faults. From these the block drives one signal, which switches on the pin's open-drain pull-down. When the pull-down is on, the pin reads "not good". When it is off, the external resistor pulls the pin high.

The two flags give the block hysteresis. Entering the good state needs the high flag. Leaving it needs the low flag. Between the two thresholds the block keeps whatever state it is in. Both transitions pass through a persistence filter, so a flag must hold for a fixed number of clock cycles (10 µs in the target clock domain) before the state changes. If the flag drops before the window is complete, the count starts again from zero. Soft-start still running, enable low, or a latched fault pulls the pin low at the next clock edge, with no filtering.

Top module: `pg_monitor`

## Requirements
- R1: After reset the block is in the not-good state with `pg_pulldown` = 1.
- R2: `pg_pulldown` goes from 1 to 0 only when `vout_hi` = 1 has been sampled, with no forcing condition, on DELAY_CYC consecutive rising edges. It changes at the last of those edges.
- R3: While `ss_done` = 0, `pg_pulldown` is 1 from the next edge onward, whatever the voltage flags are.
- R4: If the pending flag drops before the window is complete, the persistence count restarts. A fresh full window of DELAY_CYC edges is then needed.
- R5: Between the thresholds (`vout_hi` = 0 and `vout_lo` = 0) the state does not change. A good state stays released and a not-good state stays pulled low.
- R6: `pg_pulldown` goes from 0 to 1 through the filter only after `vout_lo` = 1 has been sampled on DELAY_CYC consecutive edges.
- R7: `fault_latched` = 1 or `enable` = 0 sets `pg_pulldown` to 1 at the next edge, bypassing the filter.
- R8: Polarity: `pg_pulldown` = 1 turns the pull-down on (pin low, not good), and 0 releases the pin (good).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Converter enable; 0 forces not-good |
| vout_hi | input | 1 | Output is at or above 90% of target |
| vout_lo | input | 1 | Output is 15% or more below target |
| ss_done | input | 1 | Soft-start has completed |
| fault_latched | input | 1 | A latched protection fault is active |
| pg_pulldown | output | 1 | 1 = pull-down on (not good), 0 = pin released |

## Verification
The bench times both transitions against the exact edge count. An off-by-one filter would show up as early one edge short, or still unchanged one edge late. It breaks a pending window one cycle before it expires, in both directions. A counter that holds its value instead of restarting would then switch too soon. It parks the flags between the thresholds in each state, where a design with a single threshold would toggle. It also pulses fault, enable and soft-start while the block is good, where a design that filtered those paths would keep the pin released for a full window.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
    typedef enum logic {
        PG_LOW  = 1'b0,
        PG_GOOD = 1'b1
    } pg_state_e;
endpackage

// File: rtl/pg_qualify.sv
// Chooses the flag that is pending in the current state and collects the forcing conditions.
module pg_qualify
    import pgm_pkg::*;
(
    input  pg_state_e state_q,
    input  logic      enable,
    input  logic      vout_hi,
    input  logic      vout_lo,
    input  logic      ss_done,
    input  logic      fault_latched,
    output logic      force_low,
    output logic      pending
);
    always_comb begin
        force_low = fault_latched | ~enable | ~ss_done;
        if (state_q == PG_GOOD) begin
            pending = vout_lo & ~force_low;
        end else begin
            pending = vout_hi & ~force_low;
        end
    end
endmodule

// File: rtl/pg_persist.sv
// Persistence window: counts consecutive pending cycles and flags expiry on the last one.
module pg_persist #(
    parameter int DELAY_CYC = 1250,
    parameter int CW        = $clog2(DELAY_CYC + 1)
) (
    input  logic          pending,
    input  logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d,
    output logic          expire
);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    always_comb begin
        expire = pending && (cnt_q == LAST);
        if (pending && !expire) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
    end
endmodule

// File: rtl/pg_monitor.sv
module pg_monitor
    import pgm_pkg::*;
#(
    parameter int DELAY_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic vout_hi,
    input  logic vout_lo,
    input  logic ss_done,
    input  logic fault_latched,
    output logic pg_pulldown
);
    localparam int CW = $clog2(DELAY_CYC + 1);

    typedef struct packed {
        pg_state_e     st;
        logic [CW-1:0] cnt;
    } pg_regs_t;

    pg_regs_t s_d, s_q;

    logic          force_low;
    logic          pending;
    logic          expire;
    logic [CW-1:0] cnt_nx;

    pg_qualify u_qual (
        .state_q       (s_q.st),
        .enable        (enable),
        .vout_hi       (vout_hi),
        .vout_lo       (vout_lo),
        .ss_done       (ss_done),
        .fault_latched (fault_latched),
        .force_low     (force_low),
        .pending       (pending)
    );

    pg_persist #(.DELAY_CYC(DELAY_CYC), .CW(CW)) u_persist (
        .pending (pending),
        .cnt_q   (s_q.cnt),
        .cnt_d   (cnt_nx),
        .expire  (expire)
    );

    always_comb begin
        s_d = s_q;
        if (force_low) begin
            s_d.st  = PG_LOW;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = cnt_nx;
            if (expire) begin
                s_d.st = (s_q.st == PG_GOOD) ? PG_LOW : PG_GOOD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: PG_LOW, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pg_pulldown = (s_q.st != PG_GOOD);
endmodule

// File: rtl/pgm_checker.sv
module pgm_checker #(
    parameter int DELAY_CYC = 1250
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic vout_hi,
    input logic vout_lo,
    input logic ss_done,
    input logic fault_latched,
    input logic pg_pulldown
);
    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(DELAY_CYC);

    logic          forced;
    logic [CW-1:0] hi_run_q, lo_run_q;

    assign forced = fault_latched | ~enable | ~ss_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= (vout_hi && !forced) ? ((hi_run_q == FULL) ? FULL : hi_run_q + 1'b1) : '0;
            lo_run_q <= (vout_lo && !forced) ? ((lo_run_q == FULL) ? FULL : lo_run_q + 1'b1) : '0;
        end
    end

    // R2: a release needs a full window of the high flag
    a_r2_release_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_pulldown) |-> (hi_run_q == FULL));

    // R6: a filtered deassertion needs a full window of the low flag
    a_r6_drop_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pg_pulldown) && !$past(forced)) |-> (lo_run_q == FULL));

    // R3: soft-start pending holds the pin low
    a_r3_softstart_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |=> pg_pulldown);

    // R7: fault or disable forces low at the next edge
    a_r7_force_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched || !enable) |=> pg_pulldown);

    // R5: between thresholds the output does not move
    a_r5_band_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!vout_hi && !vout_lo && !forced) |=> $stable(pg_pulldown));
endmodule

bind pg_monitor pgm_checker #(.DELAY_CYC(DELAY_CYC)) u_pgm_checker (.*);

// File: tb/tb_pg_monitor.sv
module tb_pg_monitor;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic vout_hi = 1'b0;
    logic vout_lo = 1'b0;
    logic ss_done = 1'b0;
    logic fault_latched = 1'b0;
    logic pg_pulldown;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pg_monitor #(.DELAY_CYC(N)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .vout_hi       (vout_hi),
        .vout_lo       (vout_lo),
        .ss_done       (ss_done),
        .fault_latched (fault_latched),
        .pg_pulldown   (pg_pulldown)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp);
        checks++;
        if (pg_pulldown !== exp) begin
            failures++;
            $display("FAIL %s: pg_pulldown actual=%b expected=%b at %0t", req, pg_pulldown, exp, $time);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(2);
        chk("R1 reset pull-down on", 1'b1);
        chk("R8 not-good polarity", 1'b1);
        rst_n = 1'b1;
        tick(1);
        chk("R1 idle after reset", 1'b1);
    endtask

    task automatic t_softstart_hold();
        enable = 1'b1; vout_hi = 1'b1; ss_done = 1'b0;
        tick(3 * N);
        chk("R3 held low during soft-start", 1'b1);
    endtask

    task automatic t_release();
        ss_done = 1'b1;
        tick(N - 1);
        chk("R2 no release one edge early", 1'b1);
        tick(1);
        chk("R2 release at window end", 1'b0);
        chk("R8 good releases pin", 1'b0);
    endtask

    task automatic t_band_in_good();
        vout_hi = 1'b0; vout_lo = 1'b0;
        tick(3 * N);
        chk("R5 band keeps good", 1'b0);
    endtask

    task automatic t_drop_glitch();
        vout_lo = 1'b1; tick(N - 1);
        vout_lo = 1'b0; tick(1);
        chk("R4 short sag ignored", 1'b0);
        vout_lo = 1'b1; tick(N - 1);
        chk("R4 sag window restarted", 1'b0);
        tick(1);
        chk("R6 deassert after full window", 1'b1);
    endtask

    task automatic t_band_in_low();
        vout_lo = 1'b0; vout_hi = 1'b0;
        tick(3 * N);
        chk("R5 band keeps not-good", 1'b1);
    endtask

    task automatic t_rise_glitch();
        vout_hi = 1'b1; tick(N - 1);
        vout_hi = 1'b0; tick(1);
        vout_hi = 1'b1; tick(N - 1);
        chk("R4 rise window restarted", 1'b1);
        tick(1);
        chk("R2 release after fresh window", 1'b0);
    endtask

    task automatic t_fault();
        fault_latched = 1'b1; tick(1);
        chk("R7 fault forces low at next edge", 1'b1);
        fault_latched = 1'b0; tick(N - 1);
        chk("R2 refilter after fault", 1'b1);
        tick(1);
        chk("R2 release after fault clears", 1'b0);
    endtask

    task automatic t_enable();
        enable = 1'b0; tick(1);
        chk("R7 disable forces low at next edge", 1'b1);
        enable = 1'b1; tick(N);
        chk("R2 release after re-enable", 1'b0);
    endtask

    task automatic t_ss_drop();
        ss_done = 1'b0; tick(1);
        chk("R3 soft-start restart forces low", 1'b1);
        tick(N + 2);
        chk("R3 stays low in soft-start", 1'b1);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_softstart_hold();
        t_release();
        t_band_in_good();
        t_drop_glitch();
        t_band_in_low();
        t_rise_glitch();
        t_fault();
        t_enable();
        t_ss_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule